// File: doc/BRIEF.md
# Interrupt Recognition and Type Selection

This block sits beside a processor core's sequencer and decides, each clock, whether the core takes an interrupt at the present instruction boundary and which 8-bit type it vectors to. It combines four sources: a coprocessor error fault, a software interrupt raised by the current instruction, an edge-triggered non-maskable request, and a level-sensitive maskable request. It reports the decision as a one-cycle take pulse, together with the chosen type and a flag saying whether the source's hardware status bit may be cleared.

Recognition is gated by three things. The core must strobe an instruction boundary. No bus hold may be active. No coprocessor transaction may be in flight. The interrupt-enable flag gates only the maskable request. The coprocessor error pin is looked at only while a numerics instruction runs. Fault, software and non-maskable events are remembered until they are taken, so a blocked event is not lost.

A small state machine tracks the recognizer. RUN is the normal state. STALL is entered whenever hold or a coprocessor transaction blocks recognition. TAKE lasts exactly one cycle and drives the pulse. The transitions are:
- RUN or STALL to TAKE when a boundary meets a live source and nothing blocks.
- RUN or STALL to STALL while blocked.
- STALL to RUN once unblocked with nothing accepted.
- TAKE to STALL if blocked at that moment, otherwise TAKE to RUN.

Top module: `irq_recognizer`

## Requirements
- R1: `take_pulse` is high for exactly one cycle, the cycle after the accepting boundary. `take_type` and `clr_status` are valid in that cycle, and `clr_status` is never high without `take_pulse`. A boundary presented in the pulse cycle is not acted on.
- R2: Nothing is accepted in a cycle where `boundary` is low.
- R3: Nothing is accepted while `hold_act` is high. A pending fault, software or non-maskable event stays pending and is taken at the first later boundary without hold.
- R4: Nothing is accepted while `fpu_busy` is high.
- R5: `fpu_err` is sampled only in cycles with `esc_exec` high, and is ignored otherwise. A sampled error is held until taken, and is taken as type 16 (0x10) with `clr_status` low.
- R6: A software request latches `swi_type`, which may be any value 0 to 255. It is taken whatever `ie_flag` is, always with `clr_status` low, even when the type equals a hardware type such as 2.
- R7: The maskable request is taken only when both `mreq` and `ie_flag` are high at the boundary. It uses type `mreq_type` with `clr_status` high, and it is not latched.
- R8: A rising edge on `nmi_pin` is latched and taken as type 2 with `clr_status` high, independent of `ie_flag`.
- R9: Among live sources the order is coprocessor fault, software, non-maskable, then maskable. Only the winner's pending event is cleared.
- R10: After reset, `take_pulse` and `clr_status` are 0, `take_type` is 0, and no event is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boundary | input | 1 | Instruction boundary strobe |
| ie_flag | input | 1 | Interrupt-enable flag |
| hold_act | input | 1 | Bus hold active |
| fpu_busy | input | 1 | Coprocessor transaction in flight |
| fpu_err | input | 1 | Coprocessor error pin |
| esc_exec | input | 1 | Numerics instruction executing |
| mreq | input | 1 | Maskable request level |
| mreq_type | input | 8 | Type of maskable request |
| nmi_pin | input | 1 | Non-maskable request pin |
| swi_req | input | 1 | Software interrupt request strobe |
| swi_type | input | 8 | Software interrupt type operand |
| take_pulse | output | 1 | Take-interrupt pulse |
| take_type | output | 8 | Selected interrupt type |
| clr_status | output | 1 | Clear hardware status bit of the taken source |

## Verification
A pending flag stuck at 1 shows up as an extra take pulse at the very next unblocked boundary. A flag stuck at 0 shows up as a boundary with no pulse where one is due. Both are visible one cycle after that boundary. A priority or state fault appears as a wrong `take_type` or `clr_status` inside the pulse, or as a pulse lasting two cycles. The bench compares every cycle against a reference model, so any such divergence is caught at the first cycle it reaches the ports.

// File: rtl/irq_rec_pkg.sv
package irq_rec_pkg;

    // recognizer states
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_STALL = 2'd1,
        ST_TAKE  = 2'd2
    } rec_state_e;

    // source slots, index 0 has the highest priority
    localparam int NUM_SRC   = 4;
    localparam int IDX_FAULT = 0;
    localparam int IDX_SOFT  = 1;
    localparam int IDX_NMI   = 2;
    localparam int IDX_MASK  = 3;

    // which slots own a hardware status bit
    localparam logic [NUM_SRC-1:0] HW_SLOTS = 4'b1100;

endpackage

// File: rtl/irq_src_latch.sv
module irq_src_latch #(
    parameter int TYPE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fpu_err,
    input  logic              esc_exec,
    input  logic              nmi_pin,
    input  logic              swi_req,
    input  logic [TYPE_W-1:0] swi_type,
    input  logic              clr_fault,
    input  logic              clr_soft,
    input  logic              clr_nmi,
    output logic              fault_live,
    output logic              soft_live,
    output logic [TYPE_W-1:0] soft_type,
    output logic              nmi_live
);

    logic              fault_q;
    logic              soft_q;
    logic [TYPE_W-1:0] soft_type_q;
    logic              nmi_pend_q;
    logic              nmi_prev_q;
    logic              err_sampled;
    logic              nmi_rise;

    // error pin only counts during a numerics instruction
    assign err_sampled = fpu_err & esc_exec;
    assign nmi_rise    = nmi_pin & ~nmi_prev_q;

    // live = pending from before, or arriving this cycle
    assign fault_live = fault_q | err_sampled;
    assign soft_live  = soft_q | swi_req;
    assign soft_type  = swi_req ? swi_type : soft_type_q;
    assign nmi_live   = nmi_pend_q | nmi_rise;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_q     <= 1'b0;
            soft_q      <= 1'b0;
            soft_type_q <= '0;
            nmi_pend_q  <= 1'b0;
            nmi_prev_q  <= 1'b0;
        end else begin
            fault_q    <= fault_live & ~clr_fault;
            soft_q     <= soft_live & ~clr_soft;
            nmi_pend_q <= nmi_live & ~clr_nmi;
            nmi_prev_q <= nmi_pin;
            if (swi_req) begin
                soft_type_q <= swi_type;
            end
        end
    end

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_rec_pkg::*;
#(
    parameter int TYPE_W = 8
) (
    input  logic [NUM_SRC-1:0]             req,
    input  logic [NUM_SRC-1:0][TYPE_W-1:0] src_type,
    output logic                           any_req,
    output logic [NUM_SRC-1:0]             grant,
    output logic [TYPE_W-1:0]              sel_type,
    output logic                           sel_hw
);

    // fixed priority: lower index wins
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_grant
        if (i == 0) begin : g_top
            assign grant[i] = req[i];
        end else begin : g_rest
            assign grant[i] = req[i] & ~(|req[i-1:0]);
        end
    end

    assign any_req = |req;

    // one-hot mux of type and status-clear flag
    always_comb begin
        sel_type = '0;
        sel_hw   = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (grant[i]) begin
                sel_type = sel_type | src_type[i];
                sel_hw   = sel_hw | HW_SLOTS[i];
            end
        end
    end

endmodule

// File: rtl/irq_rec_fsm.sv
module irq_rec_fsm
    import irq_rec_pkg::*;
#(
    parameter int TYPE_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               boundary,
    input  logic               blocked,
    input  logic               any_req,
    input  logic [NUM_SRC-1:0] grant,
    input  logic [TYPE_W-1:0]  sel_type,
    input  logic               sel_hw,
    output logic [NUM_SRC-1:0] clr_grant,
    output logic               take_pulse,
    output logic [TYPE_W-1:0]  take_type,
    output logic               clr_status
);

    rec_state_e state_q, state_n;
    logic       accept;

    // a boundary is not acted on during the pulse cycle
    assign accept = (state_q != ST_TAKE) && !blocked && boundary && any_req;

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_RUN, ST_STALL: begin
                if (accept) begin
                    state_n = ST_TAKE;
                end else if (blocked) begin
                    state_n = ST_STALL;
                end else begin
                    state_n = ST_RUN;
                end
            end
            ST_TAKE: begin
                state_n = blocked ? ST_STALL : ST_RUN;
            end
            default: state_n = ST_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_n;
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_type  <= '0;
            clr_status <= 1'b0;
        end else begin
            clr_status <= accept & sel_hw;
            if (accept) begin
                take_type <= sel_type;
            end
        end
    end

    assign take_pulse = (state_q == ST_TAKE);
    assign clr_grant  = accept ? grant : '0;

endmodule

// File: rtl/irq_recognizer.sv
module irq_recognizer
    import irq_rec_pkg::*;
#(
    parameter int                TYPE_W     = 8,
    parameter logic [TYPE_W-1:0] FAULT_TYPE = 8'd16,
    parameter logic [TYPE_W-1:0] NMI_TYPE   = 8'd2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boundary,
    input  logic              ie_flag,
    input  logic              hold_act,
    input  logic              fpu_busy,
    input  logic              fpu_err,
    input  logic              esc_exec,
    input  logic              mreq,
    input  logic [TYPE_W-1:0] mreq_type,
    input  logic              nmi_pin,
    input  logic              swi_req,
    input  logic [TYPE_W-1:0] swi_type,
    output logic              take_pulse,
    output logic [TYPE_W-1:0] take_type,
    output logic              clr_status
);

    logic                           fault_live;
    logic                           soft_live;
    logic                           nmi_live;
    logic [TYPE_W-1:0]              soft_type;
    logic [NUM_SRC-1:0]             req;
    logic [NUM_SRC-1:0][TYPE_W-1:0] src_type;
    logic [NUM_SRC-1:0]             grant;
    logic [NUM_SRC-1:0]             clr_grant;
    logic                           any_req;
    logic [TYPE_W-1:0]              sel_type;
    logic                           sel_hw;
    logic                           blocked;

    assign blocked = hold_act | fpu_busy;

    irq_src_latch #(.TYPE_W(TYPE_W)) u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .fpu_err    (fpu_err),
        .esc_exec   (esc_exec),
        .nmi_pin    (nmi_pin),
        .swi_req    (swi_req),
        .swi_type   (swi_type),
        .clr_fault  (clr_grant[IDX_FAULT]),
        .clr_soft   (clr_grant[IDX_SOFT]),
        .clr_nmi    (clr_grant[IDX_NMI]),
        .fault_live (fault_live),
        .soft_live  (soft_live),
        .soft_type  (soft_type),
        .nmi_live   (nmi_live)
    );

    assign req[IDX_FAULT]      = fault_live;
    assign req[IDX_SOFT]       = soft_live;
    assign req[IDX_NMI]        = nmi_live;
    assign req[IDX_MASK]       = mreq & ie_flag;
    assign src_type[IDX_FAULT] = FAULT_TYPE;
    assign src_type[IDX_SOFT]  = soft_type;
    assign src_type[IDX_NMI]   = NMI_TYPE;
    assign src_type[IDX_MASK]  = mreq_type;

    irq_arbiter #(.TYPE_W(TYPE_W)) u_arb (
        .req      (req),
        .src_type (src_type),
        .any_req  (any_req),
        .grant    (grant),
        .sel_type (sel_type),
        .sel_hw   (sel_hw)
    );

    irq_rec_fsm #(.TYPE_W(TYPE_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .boundary   (boundary),
        .blocked    (blocked),
        .any_req    (any_req),
        .grant      (grant),
        .sel_type   (sel_type),
        .sel_hw     (sel_hw),
        .clr_grant  (clr_grant),
        .take_pulse (take_pulse),
        .take_type  (take_type),
        .clr_status (clr_status)
    );

endmodule

// File: rtl/irq_recognizer_chk.sv
module irq_recognizer_chk #(
    parameter int                TYPE_W     = 8,
    parameter logic [TYPE_W-1:0] FAULT_TYPE = 8'd16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              boundary,
    input logic              hold_act,
    input logic              fpu_busy,
    input logic              fpu_err,
    input logic              esc_exec,
    input logic              take_pulse,
    input logic [TYPE_W-1:0] take_type,
    input logic              clr_status
);

    AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n) take_pulse |=> !take_pulse); // R1
    AST_CLR_IN_PULSE: assert property (@(posedge clk) disable iff (!rst_n) clr_status |-> take_pulse); // R1
    AST_NEEDS_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n) !boundary |=> !take_pulse); // R2
    AST_HOLD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n) hold_act |=> !take_pulse); // R3
    AST_COPRO_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n) fpu_busy |=> !take_pulse); // R4
    AST_FAULT_FIRST: assert property (@(posedge clk) disable iff (!rst_n) (boundary && !hold_act && !fpu_busy && !take_pulse && fpu_err && esc_exec) |=> (take_pulse && take_type == FAULT_TYPE && !clr_status)); // R5

endmodule

bind irq_recognizer irq_recognizer_chk #(
    .TYPE_W     (TYPE_W),
    .FAULT_TYPE (FAULT_TYPE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .boundary   (boundary),
    .hold_act   (hold_act),
    .fpu_busy   (fpu_busy),
    .fpu_err    (fpu_err),
    .esc_exec   (esc_exec),
    .take_pulse (take_pulse),
    .take_type  (take_type),
    .clr_status (clr_status)
);

// File: tb/tb_irq_recognizer.sv
module tb_irq_recognizer;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       boundary, ie_flag, hold_act, fpu_busy, fpu_err, esc_exec;
    logic       mreq, nmi_pin, swi_req;
    logic [7:0] mreq_type, swi_type;
    logic       take_pulse, clr_status;
    logic [7:0] take_type;

    always #5 clk = ~clk;

    irq_recognizer dut (
        .clk(clk), .rst_n(rst_n), .boundary(boundary), .ie_flag(ie_flag),
        .hold_act(hold_act), .fpu_busy(fpu_busy), .fpu_err(fpu_err),
        .esc_exec(esc_exec), .mreq(mreq), .mreq_type(mreq_type),
        .nmi_pin(nmi_pin), .swi_req(swi_req), .swi_type(swi_type),
        .take_pulse(take_pulse), .take_type(take_type), .clr_status(clr_status)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    // reference model state
    bit         m_fp, m_sp, m_np, m_nq, m_take, m_clr;
    logic [7:0] m_st, m_type;

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic idle();
        boundary = 0; ie_flag = 0; hold_act = 0; fpu_busy = 0; fpu_err = 0;
        esc_exec = 0; mreq = 0; mreq_type = 8'h00; nmi_pin = 0; swi_req = 0;
        swi_type = 8'h00;
    endtask

    // next-cycle expectation from the requirements
    task automatic model_step();
        bit         blk, fl, sl, nl, ml, acc;
        logic [7:0] st;
        int         win;
        blk = hold_act | fpu_busy;
        fl  = m_fp | (fpu_err & esc_exec);
        sl  = m_sp | swi_req;
        st  = swi_req ? swi_type : m_st;
        nl  = m_np | (nmi_pin & ~m_nq);
        ml  = mreq & ie_flag;
        acc = !m_take && !blk && boundary && (fl | sl | nl | ml);
        win = 0;
        m_clr = 0;
        if (acc) begin
            if (fl)      begin win = 1; m_type = 8'd16; end
            else if (sl) begin win = 2; m_type = st; end
            else if (nl) begin win = 3; m_type = 8'd2; m_clr = 1; end
            else         begin win = 4; m_type = mreq_type; m_clr = 1; end
        end
        m_fp   = fl && (win != 1);
        m_sp   = sl && (win != 2);
        m_np   = nl && (win != 3);
        m_st   = st;
        m_nq   = nmi_pin;
        m_take = acc;
    endtask

    task automatic step(string tag);
        model_step();
        @(negedge clk);
        chk({tag, " take"}, {15'd0, take_pulse}, {15'd0, m_take});
        chk({tag, " clr"},  {15'd0, clr_status}, {15'd0, m_clr});
        if (m_take) chk({tag, " type"}, {8'd0, take_type}, {8'd0, m_type});
    endtask

    task automatic expect_take(string tag, bit t, logic [7:0] ty, bit c);
        chk({tag, " lit take"}, {15'd0, take_pulse}, {15'd0, t});
        if (t) begin
            chk({tag, " lit type"}, {8'd0, take_type}, {8'd0, ty});
            chk({tag, " lit clr"},  {15'd0, clr_status}, {15'd0, c});
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R1 watchdog: actual hung expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        bit nmi_lvl;
        void'($urandom(32'h1B2C3D4E));
        idle();
        rst_n = 0;
        {m_fp, m_sp, m_np, m_nq, m_take, m_clr} = '0;
        m_st = 8'h00; m_type = 8'h00;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 take", {15'd0, take_pulse}, 16'd0);
        chk("R10 type", {8'd0, take_type}, 16'd0);
        chk("R10 clr",  {15'd0, clr_status}, 16'd0);
        rst_n = 1;
        step("R10 idle"); expect_take("R10", 0, 0, 0);

        // R2 no boundary, R7 gated by ie
        mreq = 1; mreq_type = 8'h45; ie_flag = 1; boundary = 0;
        step("R2"); expect_take("R2", 0, 0, 0);
        ie_flag = 0; boundary = 1;
        step("R7 ie off"); expect_take("R7", 0, 0, 0);
        ie_flag = 1;
        step("R7 ie on"); expect_take("R7", 1, 8'h45, 1);
        // R1 boundary during pulse ignored, then retaken
        step("R1 pulse"); expect_take("R1", 0, 0, 0);
        step("R1 again"); expect_take("R1", 1, 8'h45, 1);
        idle(); step("R1 idle");

        // R3 / R8 NMI edge during hold
        hold_act = 1; nmi_pin = 1;
        step("R3 nmi");
        boundary = 1;
        repeat (3) begin step("R3 held"); expect_take("R3", 0, 0, 0); end
        hold_act = 0;
        step("R8 nmi"); expect_take("R8", 1, 8'd2, 1);
        idle(); step("R8 idle");
        nmi_pin = 1; boundary = 1;
        step("R8 level"); step("R8 no retake"); expect_take("R8", 0, 0, 0);
        idle(); step("R8 idle2");

        // R5 error only sampled with esc_exec
        fpu_err = 1; boundary = 1;
        step("R5 no esc"); expect_take("R5", 0, 0, 0);
        boundary = 0; esc_exec = 1;
        step("R5 sample");
        idle(); step("R5 wait");
        boundary = 1;
        step("R5 take"); expect_take("R5", 1, 8'd16, 0);
        idle(); step("R5 idle");

        // R6 software with hardware type, ie off
        swi_req = 1; swi_type = 8'd2; boundary = 1;
        step("R6 t2"); expect_take("R6", 1, 8'd2, 0);
        idle(); step("R6 idle");
        swi_req = 1; swi_type = 8'hFF; boundary = 1;
        step("R6 tff"); expect_take("R6", 1, 8'hFF, 0);
        idle(); step("R6 idle2");

        // R4 coprocessor transaction blocks
        mreq = 1; mreq_type = 8'h20; ie_flag = 1; boundary = 1; fpu_busy = 1;
        step("R4 busy"); expect_take("R4", 0, 0, 0);
        step("R4 busy2"); expect_take("R4", 0, 0, 0);
        fpu_busy = 0;
        step("R4 free"); expect_take("R4", 1, 8'h20, 1);
        idle(); step("R4 idle");

        // R9 all sources at once
        fpu_err = 1; esc_exec = 1; swi_req = 1; swi_type = 8'h80; nmi_pin = 1;
        mreq = 1; mreq_type = 8'h33; ie_flag = 1; boundary = 1;
        step("R9 fault"); expect_take("R9", 1, 8'd16, 0);
        fpu_err = 0; esc_exec = 0; swi_req = 0;
        step("R9 gap1");
        step("R9 soft"); expect_take("R9", 1, 8'h80, 0);
        step("R9 gap2");
        step("R9 nmi"); expect_take("R9", 1, 8'd2, 1);
        step("R9 gap3");
        step("R9 mask"); expect_take("R9", 1, 8'h33, 1);
        idle(); step("R9 idle");

        // random phase
        nmi_lvl = 0;
        for (int i = 0; i < 4000; i++) begin
            boundary  = ($urandom_range(2, 0) == 0);
            ie_flag   = $urandom_range(1, 0);
            hold_act  = ($urandom_range(7, 0) == 0);
            fpu_busy  = ($urandom_range(7, 0) == 0);
            fpu_err   = ($urandom_range(3, 0) == 0);
            esc_exec  = ($urandom_range(3, 0) == 0);
            mreq      = ($urandom_range(2, 0) == 0);
            mreq_type = 8'($urandom);
            if ($urandom_range(9, 0) == 0) nmi_lvl = ~nmi_lvl;
            nmi_pin   = nmi_lvl;
            swi_req   = ($urandom_range(19, 0) == 0);
            swi_type  = 8'($urandom);
            step("R9 random");
        end

        done = 1;
        summary();
        $finish;
    end

endmodule